// File: doc/BRIEF.md
# Parallel flash command interpreter

This block models a parallel NOR flash device whose behaviour is set by a command-driven state machine. A host reaches it over a simple synchronous bus with an address, write data, a write strobe, a read strobe and registered read data. A byte array stands in for the flash cells. It is sized by a sector count and a sector length, and it comes out of reset fully erased (every byte 0xFF).

Command bytes written in sequence select what later reads return: array contents, the status register, identifier codes or bytes of a small query table. The device supports single-word program, sector erase with a confirm step, buffered program with a word count, lock and unlock sequences, and status clear. A sequence it does not recognise drops the device back to array reads. The status register is left as it was. Array words are assembled in big- or little-endian byte order according to a configuration input. A read-only input models a protected device: it blocks every cell change and reports an error bit instead.

Top module: `pflash_cmd_top`

## Requirements
- R1: After reset, reads return array data, every cell reads 0xFF, and the status register is 0x00.
- R2: When big_endian_i is 1, the byte at the lowest address of an array word sits in the most significant byte; when it is 0, that byte sits in the least significant byte. This applies to both reads and writes, and a word is DEV_BYTES wide and aligned.
- R3: Command 0x40 or 0x10 followed by a data write stores that word at the second write's address and sets status bit 7 (ready, 0x80).
- R4: With read_only_i high, a program leaves the cells unchanged and sets status bit 4 (0x10), and a confirmed erase leaves the cells unchanged and sets status bit 5 (0x20). Neither sets bit 7.
- R5: Command 0x20 followed by 0xD0 fills the whole aligned sector holding the second write's address with 0xFF and sets bit 7. Other sectors are untouched.
- R6: Command 0x20 followed by 0xFF cancels the erase and returns to array reads with the cells unchanged.
- R7: Command 0xE8 sets bit 7 at once. The next write gives the word count minus one, that many plus one data writes are stored, and a final 0xD0 ends the sequence with bit 7 set. The writes stay inside the aligned buffer window (2^8 bytes for 1-byte devices, 2^11 otherwise, clipped to the array).
- R8: Command 0x60 followed by 0x01 or 0xD0 sets bit 7. Command 0x60 followed by 0xFF returns to array reads, and any other second byte is an illegal sequence.
- R9: Command 0x50 clears the status register to 0x00.
- R10: After command 0x90, a read at word index 0 returns the manufacturer code, index 1 returns the device code, and any other index returns 0. The word index is the address divided by DEV_BYTES.
- R11: After command 0x98, a read returns the query byte at the word index: "QRY" at 0x10 to 0x12, log2 of the array size at 0x27, log2 of the buffer window at 0x2A, and sector count minus one at 0x2D. An index at or beyond QRY_LEN returns 0, and writing 0xFF returns to array reads.
- R12: An unknown first command, a bad erase, lock or buffer confirm byte, or 0xFF returns the device to array reads and leaves the status register unchanged.
- R13: While the active command is program, erase, clear, lock, status read (0x70) or buffered write, reads return the status register. Read data updates one cycle after re_i and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data or command byte (low 8 bits) |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe; read data is valid the next cycle |
| big_endian_i | input | 1 | Byte order for array words |
| read_only_i | input | 1 | Device is protected; cell changes are refused |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The bench goes after aborted and malformed sequences. An erase cancelled with 0xFF must leave the cells intact, and a design that erased on any second byte would return 0xFFFF there. A buffered write with a bad confirm byte must fall straight back to array reads with status untouched, and a design that stayed in status mode would return 0x0080 instead of the stored word. It also checks sector edges (the last word of an erased sector and the first word of the next), byte order under both endian settings, the out-of-range identifier and query indices, and the read-only error bits. A design that wrote through protection, or set ready along with the error bit, would show wrong cells or a wrong status value.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_LOCK, ST_BUF_CNT, ST_BUF_DATA, ST_BUF_CONF
  } fsm_state_e;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY} rd_mode_e;

  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFFER   = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_SET = 8'h01;

  localparam int SR_READY     = 7;
  localparam int SR_ERASE_ERR = 5;
  localparam int SR_PROG_ERR  = 4;
endpackage

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 7,
  parameter int WIN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              read_only_i,
  output rd_mode_e          mode_o,
  output logic [7:0]        status_o,
  output fsm_state_e        state_o,
  output logic              cell_we_o,
  output logic [ADDR_W-1:0] cell_addr_o,
  output logic              erase_o
);
  localparam logic [ADDR_W-1:0] WinMask = ADDR_W'((64'(1) << WIN_W) - 1);

  fsm_state_e        state_q, state_d;
  rd_mode_e          mode_q, mode_d;
  logic [7:0]        status_q, status_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] win_q, win_d;
  logic              first_q, first_d;
  logic [ADDR_W-1:0] base;

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    status_d    = status_q;
    cnt_d       = cnt_q;
    win_d       = win_q;
    first_d     = first_q;
    cell_we_o   = 1'b0;
    erase_o     = 1'b0;
    cell_addr_o = addr_i;
    base        = first_q ? addr_i : win_q;
    if (we_i) begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (op_i)
            OP_PROG_A, OP_PROG_B: begin state_d = ST_PROG;  mode_d = RD_STATUS; end
            OP_ERASE:             begin state_d = ST_ERASE; mode_d = RD_STATUS; end
            OP_LOCK:              begin state_d = ST_LOCK;  mode_d = RD_STATUS; end
            OP_CLEAR:             begin status_d = '0;      mode_d = RD_STATUS; end
            OP_STATUS:            mode_d = RD_STATUS;
            OP_IDENT:             mode_d = RD_IDENT;
            OP_QUERY:             mode_d = RD_QUERY;
            OP_BUFFER: begin
              status_d[SR_READY] = 1'b1;
              state_d = ST_BUF_CNT;
              mode_d  = RD_STATUS;
            end
            default:              mode_d = RD_ARRAY;  // 0xFF or unknown
          endcase
        end
        ST_PROG: begin
          if (read_only_i) status_d[SR_PROG_ERR] = 1'b1;
          else begin
            cell_we_o = 1'b1;
            status_d[SR_READY] = 1'b1;
          end
          state_d = ST_IDLE;
        end
        ST_ERASE: begin
          state_d = ST_IDLE;
          if (op_i == OP_CONFIRM) begin
            if (read_only_i) status_d[SR_ERASE_ERR] = 1'b1;
            else begin
              erase_o = 1'b1;
              status_d[SR_READY] = 1'b1;
            end
          end else mode_d = RD_ARRAY;
        end
        ST_LOCK: begin
          state_d = ST_IDLE;
          if (op_i == OP_CONFIRM || op_i == OP_LOCK_SET) status_d[SR_READY] = 1'b1;
          else mode_d = RD_ARRAY;
        end
        ST_BUF_CNT: begin
          cnt_d   = cnt_i;
          first_d = 1'b1;
          state_d = ST_BUF_DATA;
        end
        ST_BUF_DATA: begin
          win_d       = base;
          first_d     = 1'b0;
          cell_addr_o = (base & ~WinMask) | (addr_i & WinMask);
          if (read_only_i) status_d[SR_PROG_ERR] = 1'b1;
          else cell_we_o = 1'b1;
          if (cnt_q == '0) state_d = ST_BUF_CONF;
          else cnt_d = cnt_q - 1'b1;
        end
        ST_BUF_CONF: begin
          state_d = ST_IDLE;
          if (op_i == OP_CONFIRM) status_d[SR_READY] = 1'b1;
          else mode_d = RD_ARRAY;
        end
        default: begin
          state_d = ST_IDLE;
          mode_d  = RD_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= RD_ARRAY;
      status_q <= '0;
      cnt_q    <= '0;
      win_q    <= '0;
      first_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
      win_q    <= win_d;
      first_q  <= first_d;
    end
  end

  assign mode_o   = mode_q;
  assign status_o = status_q;
  assign state_o  = state_q;
endmodule

// File: rtl/pflash_cells.sv
module pflash_cells #(
  parameter int NB           = 2,
  parameter int TOTAL        = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int ADDR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [8*NB-1:0]   wdata_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] eaddr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [8*NB-1:0]   rdata_o
);
  localparam int DATA_W = 8 * NB;
  localparam int SHIFT  = $clog2(NB);
  localparam int SEC_W  = $clog2(SECTOR_BYTES);

  logic [7:0] mem [TOTAL];
  logic [ADDR_W-1:0] rbase;

  function automatic logic [7:0] lane_byte(input logic [DATA_W-1:0] d, input int lane,
                                           input logic be);
    return be ? d[8*(NB-1-lane) +: 8] : d[8*lane +: 8];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < TOTAL; b++) mem[b] <= 8'hFF;
    end else begin
      for (int b = 0; b < TOTAL; b++) begin
        if (erase_i && ((ADDR_W'(b) >> SEC_W) == (eaddr_i >> SEC_W)))
          mem[b] <= 8'hFF;
        else if (we_i && ((ADDR_W'(b) >> SHIFT) == (waddr_i >> SHIFT)))
          mem[b] <= lane_byte(wdata_i, b % NB, big_endian_i);
      end
    end
  end

  assign rbase = (raddr_i >> SHIFT) << SHIFT;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (big_endian_i) rdata_o[8*(NB-1-i) +: 8] = mem[rbase + ADDR_W'(i)];
      else              rdata_o[8*i +: 8]        = mem[rbase + ADDR_W'(i)];
    end
  end
endmodule

// File: rtl/pflash_query_rom.sv
module pflash_query_rom #(
  parameter int TOTAL        = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4,
  parameter int BUF_LOG2     = 11,
  parameter int QRY_LEN      = 49
) (
  input  logic [7:0] idx_i,
  output logic [7:0] byte_o
);
  localparam int NSM1 = NUM_SECTORS - 1;

  always_comb begin
    byte_o = 8'h00;
    if (32'(idx_i) < QRY_LEN) begin
      unique case (idx_i)
        8'h10: byte_o = 8'h51;
        8'h11: byte_o = 8'h52;
        8'h12: byte_o = 8'h59;
        8'h13: byte_o = 8'h01;
        8'h15: byte_o = 8'h31;
        8'h27: byte_o = 8'($clog2(TOTAL));
        8'h28: byte_o = 8'h02;
        8'h2A: byte_o = 8'(BUF_LOG2);
        8'h2C: byte_o = 8'h01;
        8'h2D: byte_o = 8'(NSM1);
        8'h2E: byte_o = 8'(NSM1 >> 8);
        8'h2F: byte_o = 8'(SECTOR_BYTES >> 8);
        8'h30: byte_o = 8'(SECTOR_BYTES >> 16);
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pflash_cmd_top.sv
module pflash_cmd_top
  import pflash_pkg::*;
#(
  parameter int          NUM_SECTORS  = 4,
  parameter int          SECTOR_BYTES = 64,
  parameter int          DEV_BYTES    = 2,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018,
  parameter int          QRY_LEN      = 49,
  localparam int         TOTAL        = NUM_SECTORS * SECTOR_BYTES,
  localparam int         ADDR_W       = $clog2(TOTAL),
  localparam int         DATA_W       = 8 * DEV_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              big_endian_i,
  input  logic              read_only_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int SHIFT    = $clog2(DEV_BYTES);
  localparam int BUF_LOG2 = (DEV_BYTES == 1) ? 8 : 11;
  localparam int WIN_W    = (BUF_LOG2 < ADDR_W) ? BUF_LOG2 : ADDR_W;
  localparam int CNT_W    = (WIN_W - SHIFT < 1) ? 1 : WIN_W - SHIFT;

  rd_mode_e          mode_w;
  fsm_state_e        state_w;
  logic [7:0]        status_w;
  logic              cell_we_w, erase_w;
  logic [ADDR_W-1:0] cell_addr_w;
  logic [DATA_W-1:0] array_word;
  logic [7:0]        qry_byte, idx;
  logic [31:0]       rd_value;

  pflash_cmd_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_fsm (
    .clk_i, .rst_ni, .we_i, .addr_i,
    .op_i(wdata_i[7:0]), .cnt_i(wdata_i[CNT_W-1:0]), .read_only_i,
    .mode_o(mode_w), .status_o(status_w), .state_o(state_w),
    .cell_we_o(cell_we_w), .cell_addr_o(cell_addr_w), .erase_o(erase_w)
  );

  pflash_cells #(.NB(DEV_BYTES), .TOTAL(TOTAL), .SECTOR_BYTES(SECTOR_BYTES),
                 .ADDR_W(ADDR_W)) u_cells (
    .clk_i, .rst_ni, .big_endian_i,
    .we_i(cell_we_w), .waddr_i(cell_addr_w), .wdata_i,
    .erase_i(erase_w), .eaddr_i(addr_i),
    .raddr_i(addr_i), .rdata_o(array_word)
  );

  assign idx = 8'(addr_i >> SHIFT);

  pflash_query_rom #(.TOTAL(TOTAL), .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS),
                     .BUF_LOG2(BUF_LOG2), .QRY_LEN(QRY_LEN)) u_rom (
    .idx_i(idx), .byte_o(qry_byte)
  );

  always_comb begin
    unique case (mode_w)
      RD_STATUS: rd_value = {24'h0, status_w};
      RD_IDENT:  rd_value = (idx == 8'd0) ? {16'h0, MFR_ID} :
                            (idx == 8'd1) ? {16'h0, DEV_ID} : 32'h0;
      RD_QUERY:  rd_value = {24'h0, qry_byte};
      default:   rd_value = 32'(array_word);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= DATA_W'(rd_value);
  end
endmodule

// File: rtl/pflash_cmd_chk.sv
module pflash_cmd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic              read_only_i,
  input logic [7:0]        op_i,
  input logic [7:0]        status_i,
  input logic [2:0]        state_i,
  input logic [1:0]        mode_i,
  input logic              cell_we_i,
  input logic              erase_i,
  input logic [DATA_W-1:0] rdata_i
);
  p_ro_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_only_i |-> !(cell_we_i || erase_i));

  p_single_op_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cell_we_i, erase_i}));

  p_erase_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> status_i[7]);

  p_buf_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && state_i == 3'd0 && op_i == 8'hE8) |=> status_i[7]);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && state_i == 3'd0 && op_i == 8'h50) |=> status_i == 8'h00);

  p_status_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(status_i));

  p_mode_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mode_i) && $stable(state_i)));

  p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i));
endmodule

bind pflash_cmd_top pflash_cmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
  .read_only_i(read_only_i), .op_i(wdata_i[7:0]), .status_i(status_w),
  .state_i(state_w), .mode_i(mode_w), .cell_we_i(cell_we_w),
  .erase_i(erase_w), .rdata_i(rdata_o)
);

// File: tb/pflash_cmd_top_bench.sv
module pflash_cmd_top_bench;
  localparam int TOTAL = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, be = 1'b0, ro = 1'b0;
  logic [15:0] rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] ref_mem [TOTAL];
  logic [7:0] st = 8'h00;

  always #10 clk = ~clk;

  pflash_cmd_top u_pflash_cmd_top (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .big_endian_i(be), .read_only_i(ro), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic logic [15:0] ref_word(input logic [7:0] a);
    logic [7:0] b = {a[7:1], 1'b0};
    return be ? {ref_mem[b], ref_mem[b+1]} : {ref_mem[b+1], ref_mem[b]};
  endfunction

  task automatic ref_store(input logic [7:0] a, input logic [15:0] d);
    logic [7:0] b = {a[7:1], 1'b0};
    if (be) begin ref_mem[b] = d[15:8]; ref_mem[b+1] = d[7:0]; end
    else    begin ref_mem[b] = d[7:0];  ref_mem[b+1] = d[15:8]; end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic prog(input logic [7:0] op, input logic [7:0] a, input logic [15:0] d);
    wr(a, {8'h00, op});
    wr(a, d);
    if (ro) st[4] = 1'b1;
    else begin ref_store(a, d); st[7] = 1'b1; end
  endtask

  task automatic clear_status();
    wr(8'h00, 16'h0050); st = 8'h00;
  endtask

  task automatic t_reset();
    rd_chk("R1 erased cell", 8'h00, 16'hFFFF);
    rd_chk("R1 erased cell high", 8'hFE, 16'hFFFF);
    wr(8'h00, 16'h0070);
    rd_chk("R1 status zero", 8'h00, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_program();
    be = 1'b0;
    prog(8'h40, 8'h10, 16'h1234);
    rd_chk("R3 status after 0x40", 8'h10, 16'h0080);
    rd_chk("R13 status read repeat", 8'h22, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R3 stored word", 8'h10, 16'h1234);
    prog(8'h10, 8'h12, 16'hA55A);
    rd_chk("R3 status after 0x10", 8'h12, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R3 stored word 0x10", 8'h12, ref_word(8'h12));
  endtask

  task automatic t_endian();
    be = 1'b1;
    rd_chk("R2 big-endian view", 8'h10, 16'h3412);
    prog(8'h40, 8'h14, 16'hCAFE);
    wr(8'h00, 16'h00FF);
    rd_chk("R2 big-endian write", 8'h14, 16'hCAFE);
    be = 1'b0;
    rd_chk("R2 little-endian view", 8'h14, 16'hFECA);
    chk("R2 model word", ref_word(8'h14), 16'hFECA);
  endtask

  task automatic t_erase();
    prog(8'h40, 8'h48, 16'h1111);
    prog(8'h40, 8'h80, 16'h2222);
    prog(8'h40, 8'h3E, 16'h3333);
    wr(8'h50, 16'h0020);
    wr(8'h52, 16'h00D0);
    for (int b = 64; b < 128; b++) ref_mem[b] = 8'hFF;
    st[7] = 1'b1;
    rd_chk("R5 status after erase", 8'h00, {8'h00, st});
    wr(8'h00, 16'h00FF);
    rd_chk("R5 sector cleared", 8'h48, 16'hFFFF);
    rd_chk("R5 sector last word", 8'h7E, 16'hFFFF);
    rd_chk("R5 next sector kept", 8'h80, 16'h2222);
    rd_chk("R5 prior sector kept", 8'h3E, 16'h3333);
  endtask

  task automatic t_erase_cancel();
    prog(8'h40, 8'h30, 16'h4444);
    wr(8'h30, 16'h0020);
    wr(8'h30, 16'h00FF);
    rd_chk("R6 cancel keeps cells", 8'h30, 16'h4444);
  endtask

  task automatic t_clear();
    clear_status();
    rd_chk("R9 status cleared", 8'h00, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_buffer();
    wr(8'hA0, 16'h00E8); st[7] = 1'b1;
    rd_chk("R7 ready after 0xE8", 8'hA0, 16'h0080);
    wr(8'hA0, 16'h0002);
    wr(8'hA0, 16'h0101); ref_store(8'hA0, 16'h0101);
    wr(8'hA2, 16'h0202); ref_store(8'hA2, 16'h0202);
    wr(8'hA4, 16'h0303); ref_store(8'hA4, 16'h0303);
    wr(8'hA0, 16'h00D0);
    rd_chk("R7 status after confirm", 8'h00, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R7 buffer word 0", 8'hA0, 16'h0101);
    rd_chk("R7 buffer word 1", 8'hA2, 16'h0202);
    rd_chk("R7 buffer word 2", 8'hA4, 16'h0303);
    rd_chk("R7 word past count", 8'hA6, 16'hFFFF);
  endtask

  task automatic t_buffer_bad();
    clear_status();
    wr(8'hB0, 16'h00E8); st[7] = 1'b1;
    wr(8'hB0, 16'h0000);
    wr(8'hB0, 16'h5A5A); ref_store(8'hB0, 16'h5A5A);
    wr(8'hB0, 16'h0055);
    rd_chk("R12 bad confirm to array", 8'hB0, 16'h5A5A);
    wr(8'h00, 16'h0070);
    rd_chk("R12 status kept", 8'h00, 16'h0080);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_lock();
    clear_status();
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0001); st[7] = 1'b1;
    rd_chk("R8 lock ready", 8'h00, 16'h0080);
    clear_status();
    wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0); st[7] = 1'b1;
    rd_chk("R8 unlock ready", 8'h00, 16'h0080);
    wr(8'h00, 16'h0060); wr(8'h00, 16'h00FF);
    rd_chk("R8 0xFF to array", 8'h10, 16'h1234);
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0033);
    rd_chk("R8 bad second byte to array", 8'h10, 16'h1234);
    wr(8'h00, 16'h0070);
    rd_chk("R12 status after bad lock", 8'h00, 16'h0080);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_ident();
    wr(8'h00, 16'h0090);
    rd_chk("R10 manufacturer", 8'h00, 16'h0089);
    rd_chk("R10 device", 8'h02, 16'h0018);
    rd_chk("R10 other index", 8'h04, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_query();
    wr(8'h00, 16'h0098);
    rd_chk("R11 Q", 8'h20, 16'h0051);
    rd_chk("R11 R", 8'h22, 16'h0052);
    rd_chk("R11 Y", 8'h24, 16'h0059);
    rd_chk("R11 size log2", 8'h4E, 16'h0008);
    rd_chk("R11 buffer log2", 8'h54, 16'h000B);
    rd_chk("R11 sectors-1", 8'h5A, 16'h0003);
    rd_chk("R11 index at length", 8'h62, 16'h0000);
    rd_chk("R11 index beyond", 8'h80, 16'h0000);
    wr(8'h00, 16'h00FF);
    rd_chk("R11 exit to array", 8'h10, 16'h1234);
  endtask

  task automatic t_read_only();
    ro = 1'b1;
    clear_status();
    prog(8'h40, 8'h60, 16'hBEEF);
    rd_chk("R4 program error bit", 8'h00, 16'h0010);
    wr(8'h00, 16'h00FF);
    rd_chk("R4 cell unchanged", 8'h60, 16'hFFFF);
    clear_status();
    wr(8'h10, 16'h0020); wr(8'h10, 16'h00D0); st[5] = 1'b1;
    rd_chk("R4 erase error bit", 8'h00, 16'h0020);
    wr(8'h00, 16'h00FF);
    rd_chk("R4 sector unchanged", 8'h10, 16'h1234);
    ro = 1'b0;
  endtask

  task automatic t_unknown();
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h0033);
    rd_chk("R12 unknown cmd to array", 8'h10, 16'h1234);
    wr(8'h00, 16'h0070);
    rd_chk("R12 status unchanged", 8'h00, {8'h00, st});
    wr(8'h00, 16'h00FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < TOTAL; b++) ref_mem[b] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_endian();
    t_erase();
    t_erase_cancel();
    t_clear();
    t_buffer();
    t_buffer_bad();
    t_lock();
    t_ident();
    t_query();
    t_read_only();
    t_unknown();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule